// File: doc/BRIEF.md
# Grouped Event Counter Performance Monitor

This block is a memory-mapped performance monitor. It holds a bank of event counters, split into groups of equal size. Each counter has an event-select register that picks one of the event strobe inputs. A counter adds one on each clock cycle in which its selected strobe is high, but only when three enables are all set: the global enable, the enable of its group and its own enable bit. Counter n belongs to group n / (counters per group).

Software reaches the block through a plain bus with valid, write, address and write-data signals. Read data is combinational and is valid in the same cycle as a read access. Each counter has three state bits: count enable, interrupt enable and overflow status. Each kind is packed into 32-bit words, with counter n at word n/32, bit n%32, and consecutive words 4 bytes apart. The enable bits change only through separate set and clear words. Overflow bits are cleared by writing 1s. A counter that wraps past all-ones sets its overflow bit, and a level interrupt reports any overflow whose interrupt enable is set.

Address map (byte offsets): 0x000 control, 0x004 configuration, 0x100+4g group g control, 0x200+4w count-enable set, 0x240+4w count-enable clear, 0x280+4w interrupt-enable set, 0x2C0+4w interrupt-enable clear, 0x300+4w overflow status, 0x400+4n counter n value, 0x600+4n counter n event select.

Top module: `gem_top`

## Requirements
- R1: Bit 0 of the control register (0x000) is the global enable and reads back. While it is 0, no counter changes.
- R2: A write to 0x000 with bit 1 set clears every counter to zero at that clock edge, and the count enable state is not changed. Bit 1 always reads as 0.
- R3: Bit 11 of group control register 0x100+4g enables counting for counters g*CPG to g*CPG+CPG-1, where CPG = counters / groups. When this bit is 0, those counters hold their value.
- R4: Bits 27:24 of each implemented group register read CPG. The configuration register 0x004 reads the total counter count in bits 7:0 and the group count in bits 31:24, and it ignores writes.
- R5: Counter n (read at 0x400+4n) adds one per cycle when all three enables are set and event input e is high, where e is the value in its event-select register at 0x600+4n. The event-select value reads back.
- R6: Writing 1s to count-enable set word 0x200+4w sets those enable bits, and writing 1s to clear word 0x240+4w clears them. Zero bits leave the state unchanged. Reading either word returns the current enable bitmap.
- R7: Interrupt enables use the same set/clear scheme at 0x280+4w (set) and 0x2C0+4w (clear), and reading either word returns the bitmap.
- R8: Writing 1 to a bit of overflow word 0x300+4w clears that status bit. Writing 0 has no effect.
- R9: When counter n steps from all-ones to zero, overflow status bit n becomes 1 at the same edge.
- R10: If a clear write to an overflow bit and a new overflow of that counter happen in the same cycle, the bit ends up set.
- R11: irq is high exactly when some counter has both its overflow status and its interrupt enable set. It stays high until software clears those bits.
- R12: Reads of unimplemented counters, groups, bitmap words or unmapped offsets return zero.
- R13: After reset, all enables, interrupt enables, overflow bits, event selects and counters are zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_vld | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| evt_in | input | NUM_EVT | Event strobes, one count per high cycle |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench drives a counter to exactly all-ones and then issues the overflow clear write in the same cycle as the wrapping event. A design that lets the clear win would lose that overflow and read the bit back as 0. It checks that a zero-valued overflow write and zero-valued set/clear writes leave the bitmaps unchanged, which catches a design that writes the data directly into the bitmap. It checks that disabling only the global or only one group stops exactly the affected counters, which exposes a design that gates on the wrong group index or skips one of the three enables. It also checks that a clear-all on the control register zeroes counts without disturbing the enable state.

// File: rtl/gem_pkg.sv
package gem_pkg;

    localparam int DW = 32;
    localparam int AW = 12;
    localparam int IW = 7;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;
    localparam int GRP_EN_BIT   = 11;
    localparam int GRP_N_LSB    = 24;
    localparam int CFG_GRP_LSB  = 24;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_CTRL,
        RK_CFG,
        RK_GRP,
        RK_ENSET,
        RK_ENCLR,
        RK_IESET,
        RK_IECLR,
        RK_OVS,
        RK_CNT,
        RK_EVT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e       kind;
        logic [IW-1:0]   idx;
    } reg_sel_t;

    function automatic reg_sel_t gem_decode(input logic [AW-1:0] a);
        reg_sel_t r;
        r.kind = RK_NONE;
        r.idx  = '0;
        unique case (a[11:9])
            3'b000: begin
                if (!a[8]) begin
                    if (a[7:2] == 6'd0)      r.kind = RK_CTRL;
                    else if (a[7:2] == 6'd1) r.kind = RK_CFG;
                end else begin
                    r.kind = RK_GRP;
                    r.idx  = {1'b0, a[7:2]};
                end
            end
            3'b001: begin
                if (!a[8]) begin
                    r.idx = {3'b000, a[5:2]};
                    unique case (a[7:6])
                        2'd0: r.kind = RK_ENSET;
                        2'd1: r.kind = RK_ENCLR;
                        2'd2: r.kind = RK_IESET;
                        default: r.kind = RK_IECLR;
                    endcase
                end else begin
                    r.kind = RK_OVS;
                    r.idx  = {1'b0, a[7:2]};
                end
            end
            3'b010: begin
                r.kind = RK_CNT;
                r.idx  = a[8:2];
            end
            3'b011: begin
                r.kind = RK_EVT;
                r.idx  = a[8:2];
            end
            default: r.kind = RK_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gem_ctrl.sv
module gem_ctrl
    import gem_pkg::*;
#(
    parameter int NUM_GRP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              grp_we,
    input  logic [IW-1:0]     grp_idx,
    input  logic [DW-1:0]     wdata,
    output logic              glb_en_q,
    output logic [NUM_GRP-1:0] grp_en_q,
    output logic              cnt_clr
);

    assign cnt_clr = ctrl_we & wdata[CTRL_CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en_q <= 1'b0;
        end else if (ctrl_we) begin
            glb_en_q <= wdata[CTRL_EN_BIT];
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst) begin
                grp_en_q[g] <= 1'b0;
            end else if (grp_we && grp_idx == IW'(g)) begin
                grp_en_q[g] <= wdata[GRP_EN_BIT];
            end
        end
    end

    AST_GLB_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> $stable(glb_en_q)); // R1

    AST_GRP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !grp_we |=> $stable(grp_en_q)); // R3

endmodule

// File: rtl/gem_bitmap.sv
module gem_bitmap
    import gem_pkg::*;
#(
    parameter int NUM_CNT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_we,
    input  logic               clr_we,
    input  logic [IW-1:0]      widx,
    input  logic [DW-1:0]      wdata,
    output logic [NUM_CNT-1:0] bits_q
);

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_bit
        localparam int WRD = n / DW;
        localparam int POS = n % DW;
        logic hit;
        assign hit = (widx == IW'(WRD)) && wdata[POS];

        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q[n] <= 1'b0;
            end else if (set_we && hit) begin
                bits_q[n] <= 1'b1;
            end else if (clr_we && hit) begin
                bits_q[n] <= 1'b0;
            end
        end
    end

    AST_SET_CLR_APART: assert property (@(posedge clk) disable iff (rst)
        !(set_we && clr_we)); // R6

    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(bits_q)); // R7

endmodule

// File: rtl/gem_counter.sv
module gem_counter #(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 4,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               cnt_on,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               sel_we,
    input  logic [SEL_W-1:0]   sel_wdata,
    output logic [SEL_W-1:0]   sel_q,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               wrap
);

    localparam int EVP = 1 << SEL_W;

    logic [EVP-1:0] evt_pad;
    logic           hit;

    assign evt_pad = EVP'(evt_in);
    assign hit     = cnt_on & evt_pad[sel_q];
    assign wrap    = hit & (&cnt_q) & ~clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= sel_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0)); // R2

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cnt_on && !clr) |=> $stable(cnt_q)); // R1

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt_q == '0)); // R9

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (cnt_on && !clr && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R5

endmodule

// File: rtl/gem_ovf_status.sv
module gem_ovf_status #(
    parameter int NUM_CNT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CNT-1:0] set_vec,
    input  logic [NUM_CNT-1:0] clr_vec,
    output logic [NUM_CNT-1:0] ovs_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovs_q <= '0;
        end else begin
            ovs_q <= (ovs_q & ~clr_vec) | set_vec;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((ovs_q & $past(set_vec)) == $past(set_vec))); // R10

    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (|(ovs_q & ~clr_vec)) |=> ((ovs_q & $past(ovs_q & ~clr_vec)) == $past(ovs_q & ~clr_vec))); // R8

    AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (rst)
        (set_vec == '0) |=> ((ovs_q & ~$past(ovs_q)) == '0)); // R9

endmodule

// File: rtl/gem_top.sv
module gem_top
    import gem_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int NUM_GRP = 2,
    parameter int NUM_EVT = 4,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_vld,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);

    localparam int CPG       = NUM_CNT / NUM_GRP;
    localparam int NUM_WORDS = (NUM_CNT + DW - 1) / DW;
    localparam int PADW      = NUM_WORDS * DW;
    localparam int SEL_W     = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    reg_sel_t rs;
    logic     wr_any;
    logic     rd_any;

    assign rs     = gem_decode(bus_addr);
    assign wr_any = bus_vld & bus_wr;
    assign rd_any = bus_vld & ~bus_wr;

    logic               glb_en;
    logic [NUM_GRP-1:0] grp_en;
    logic               cnt_clr;
    logic [NUM_CNT-1:0] cen_q;
    logic [NUM_CNT-1:0] ien_q;
    logic [NUM_CNT-1:0] ovs_q;
    logic [NUM_CNT-1:0] wrap_vec;
    logic [NUM_CNT-1:0] ovs_clr;
    logic [CNT_W-1:0]   cnt_vals [NUM_CNT];
    logic [SEL_W-1:0]   sel_vals [NUM_CNT];

    gem_ctrl #(.NUM_GRP(NUM_GRP)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (wr_any && rs.kind == RK_CTRL),
        .grp_we   (wr_any && rs.kind == RK_GRP),
        .grp_idx  (rs.idx),
        .wdata    (bus_wdata),
        .glb_en_q (glb_en),
        .grp_en_q (grp_en),
        .cnt_clr  (cnt_clr)
    );

    gem_bitmap #(.NUM_CNT(NUM_CNT)) u_cen (
        .clk    (clk),
        .rst    (rst),
        .set_we (wr_any && rs.kind == RK_ENSET),
        .clr_we (wr_any && rs.kind == RK_ENCLR),
        .widx   (rs.idx),
        .wdata  (bus_wdata),
        .bits_q (cen_q)
    );

    gem_bitmap #(.NUM_CNT(NUM_CNT)) u_ien (
        .clk    (clk),
        .rst    (rst),
        .set_we (wr_any && rs.kind == RK_IESET),
        .clr_we (wr_any && rs.kind == RK_IECLR),
        .widx   (rs.idx),
        .wdata  (bus_wdata),
        .bits_q (ien_q)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        localparam int GRP = n / CPG;
        logic on;
        assign on         = glb_en & grp_en[GRP] & cen_q[n];
        assign ovs_clr[n] = wr_any && rs.kind == RK_OVS && rs.idx == IW'(n / DW)
                            && bus_wdata[n % DW];

        gem_counter #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .clr       (cnt_clr),
            .cnt_on    (on),
            .evt_in    (evt_in),
            .sel_we    (wr_any && rs.kind == RK_EVT && rs.idx == IW'(n)),
            .sel_wdata (bus_wdata[SEL_W-1:0]),
            .sel_q     (sel_vals[n]),
            .cnt_q     (cnt_vals[n]),
            .wrap      (wrap_vec[n])
        );
    end

    gem_ovf_status #(.NUM_CNT(NUM_CNT)) u_ovs (
        .clk     (clk),
        .rst     (rst),
        .set_vec (wrap_vec),
        .clr_vec (ovs_clr),
        .ovs_q   (ovs_q)
    );

    assign irq = |(ovs_q & ien_q);

    function automatic logic [DW-1:0] pick_word(input logic [NUM_CNT-1:0] v,
                                                input logic [IW-1:0] w);
        logic [PADW-1:0] pad;
        logic [DW-1:0]   r;
        pad = PADW'(v);
        r   = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (w == IW'(k)) r = pad[k*DW +: DW];
        end
        return r;
    endfunction

    always_comb begin
        bus_rdata = '0;
        if (rd_any) begin
            unique case (rs.kind)
                RK_CTRL: bus_rdata[CTRL_EN_BIT] = glb_en;
                RK_CFG: begin
                    bus_rdata[7:0]                     = 8'(NUM_CNT);
                    bus_rdata[CFG_GRP_LSB +: 8]        = 8'(NUM_GRP);
                end
                RK_GRP: begin
                    for (int g = 0; g < NUM_GRP; g++) begin
                        if (rs.idx == IW'(g)) begin
                            bus_rdata[GRP_EN_BIT]        = grp_en[g];
                            bus_rdata[GRP_N_LSB +: 4]    = 4'(CPG);
                        end
                    end
                end
                RK_ENSET, RK_ENCLR: bus_rdata = pick_word(cen_q, rs.idx);
                RK_IESET, RK_IECLR: bus_rdata = pick_word(ien_q, rs.idx);
                RK_OVS:             bus_rdata = pick_word(ovs_q, rs.idx);
                RK_CNT: begin
                    for (int n = 0; n < NUM_CNT; n++) begin
                        if (rs.idx == IW'(n)) bus_rdata = DW'(cnt_vals[n]);
                    end
                end
                RK_EVT: begin
                    for (int n = 0; n < NUM_CNT; n++) begin
                        if (rs.idx == IW'(n)) bus_rdata = DW'(sel_vals[n]);
                    end
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_any && (rs.kind == RK_OVS || rs.kind == RK_IECLR))) |=> irq); // R11

    AST_IRQ_NEEDS_OVF: assert property (@(posedge clk) disable iff (rst)
        (ovs_q == '0) |-> !irq); // R11

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!irq && !glb_en && cen_q == '0)); // R13

endmodule

// File: tb/gem_top_bench.sv
module gem_top_bench;

    localparam int NC = 8;
    localparam int NG = 2;
    localparam int NE = 4;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_vld;
    logic          bus_wr;
    logic [11:0]   bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NE-1:0] evt_in;
    logic          irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    gem_top #(.NUM_CNT(NC), .NUM_GRP(NG), .NUM_EVT(NE), .CNT_W(CW)) u_gem_top (
        .clk(clk), .rst(rst), .bus_vld(bus_vld), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .irq(irq)
    );

    localparam logic [11:0] A_CTRL = 12'h000, A_CFG = 12'h004, A_GRP = 12'h100,
                            A_ENS = 12'h200, A_ENC = 12'h240, A_IES = 12'h280,
                            A_IEC = 12'h2C0, A_OVS = 12'h300, A_CNT = 12'h400,
                            A_EVT = 12'h600;

    typedef struct packed {
        logic [3:0]  mask;
        logic [7:0]  cyc;
        logic [2:0]  idx;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'b0001, 8'd5,  3'd0, 32'd5},
        '{4'b0001, 8'd5,  3'd1, 32'd0},
        '{4'b0010, 8'd7,  3'd1, 32'd7},
        '{4'b0010, 8'd7,  3'd5, 32'd7},
        '{4'b1100, 8'd3,  3'd2, 32'd3},
        '{4'b1100, 8'd3,  3'd7, 32'd3},
        '{4'b1111, 8'd10, 3'd4, 32'd10},
        '{4'b1000, 8'd2,  3'd6, 32'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_vld = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        d = bus_rdata;
        @(negedge clk);
        bus_vld = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic pulse(input logic [NE-1:0] m, input int cyc);
        @(negedge clk);
        evt_in = m;
        repeat (cyc) @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_vld = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; evt_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        rchk("R13 ctrl", A_CTRL, 32'h0);
        rchk("R13 enables", A_ENS, 32'h0);
        rchk("R13 overflow", A_OVS, 32'h0);
        rchk("R13 counter", A_CNT + 12'd12, 32'h0);
        chk("R13 irq", {31'b0, irq}, 32'h0);
        // R4 configuration and group size field
        rchk("R4 config", A_CFG, 32'h0200_0008);
        rchk("R4 group size", A_GRP, 32'h0400_0000);

        // setup: all enabled, counter n selects event n%4
        wr(A_CTRL, 32'h1);
        wr(A_GRP, 32'h800);
        wr(A_GRP + 12'd4, 32'h800);
        wr(A_ENS, 32'hFF);
        for (int n = 0; n < NC; n++) wr(A_EVT + 12'(4 * n), 32'(n % 4));
        rchk("R3 group enable readback", A_GRP + 12'd4, 32'h0400_0800);
        rchk("R1 enable readback", A_CTRL, 32'h1);

        // R5 vector table
        for (int v = 0; v < 8; v++) begin
            wr(A_CTRL, 32'h3);
            pulse(VECS[v].mask, int'(VECS[v].cyc));
            rchk($sformatf("R5 vector %0d", v), A_CNT + 12'(4 * VECS[v].idx), VECS[v].exp);
        end
        rchk("R2 clear bit reads zero", A_CTRL, 32'h1);

        // R2 clear keeps enables, R1 global disable
        wr(A_CTRL, 32'h2);
        rchk("R2 counters cleared", A_CNT + 12'd16, 32'h0);
        rchk("R2 enables kept", A_ENS, 32'hFF);
        pulse(4'b1111, 5);
        rchk("R1 global off holds", A_CNT, 32'h0);

        // R3 group disable
        wr(A_CTRL, 32'h3);
        wr(A_GRP + 12'd4, 32'h0);
        pulse(4'b1111, 4);
        rchk("R3 group0 counts", A_CNT, 32'd4);
        rchk("R3 group1 holds", A_CNT + 12'd16, 32'd0);
        wr(A_GRP + 12'd4, 32'h800);

        // R9 overflow, R11 irq, R8 W1C
        wr(A_CTRL, 32'h3);
        pulse(4'b0001, 256);
        rchk("R9 wrapped value", A_CNT, 32'h0);
        rchk("R9 overflow bits", A_OVS, 32'h11);
        chk("R11 irq masked", {31'b0, irq}, 32'h0);
        wr(A_IES, 32'h1);
        chk("R11 irq raised", {31'b0, irq}, 32'h1);
        rchk("R7 ie readback", A_IEC, 32'h1);
        wr(A_OVS, 32'h0);
        rchk("R8 zero write no effect", A_OVS, 32'h11);
        wr(A_OVS, 32'h10);
        rchk("R8 clear one bit", A_OVS, 32'h01);
        chk("R11 irq held", {31'b0, irq}, 32'h1);

        // R10 set beats clear in the same cycle
        wr(A_CTRL, 32'h3);
        pulse(4'b0001, 255);
        rchk("R10 at all-ones", A_CNT, 32'hFF);
        @(negedge clk);
        evt_in = 4'b0001;
        bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = A_OVS; bus_wdata = 32'h1;
        @(negedge clk);
        evt_in = '0; bus_vld = 1'b0; bus_wr = 1'b0;
        rchk("R10 set wins", A_OVS, 32'h11);
        wr(A_OVS, 32'h11);
        rchk("R8 all cleared", A_OVS, 32'h0);
        chk("R11 irq dropped", {31'b0, irq}, 32'h0);

        // R6 set/clear count enables
        wr(A_ENC, 32'h1);
        rchk("R6 clear one", A_ENS, 32'hFE);
        wr(A_ENS, 32'h0);
        rchk("R6 zero set no effect", A_ENC, 32'hFE);
        wr(A_ENC, 32'h0);
        rchk("R6 zero clear no effect", A_ENS, 32'hFE);
        wr(A_CTRL, 32'h3);
        pulse(4'b0001, 3);
        rchk("R6 disabled holds", A_CNT, 32'h0);
        rchk("R6 enabled counts", A_CNT + 12'd16, 32'd3);
        wr(A_ENS, 32'h1);
        rchk("R6 set back", A_ENS, 32'hFF);

        // R7 interrupt enable clear
        wr(A_IEC, 32'h1);
        rchk("R7 ie cleared", A_IES, 32'h0);

        // R5 reselect event
        wr(A_EVT + 12'd8, 32'h3);
        rchk("R5 select readback", A_EVT + 12'd8, 32'h3);
        wr(A_CTRL, 32'h3);
        pulse(4'b1000, 2);
        rchk("R5 new event counted", A_CNT + 12'd8, 32'd2);

        // R12 unimplemented reads
        rchk("R12 counter 9", A_CNT + 12'd36, 32'h0);
        rchk("R12 group 3", A_GRP + 12'd12, 32'h0);
        rchk("R12 bitmap word 1", A_ENS + 12'd4, 32'h0);
        rchk("R12 unmapped", 12'h008, 32'h0);
        wr(A_CFG, 32'hFFFF_FFFF);
        rchk("R4 config ignores write", A_CFG, 32'h0200_0008);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule